// File: doc/BRIEF.md
# Prioritised Service Request Arbiter

This block gathers service requests from a parameterised set of request nodes and hands each one to the service provider it is routed to. Each node holds a pending flag, an enable bit, an 8-bit priority number and a target field that selects one of the service providers, for example a CPU, a peripheral processor or a DMA engine. Every provider has its own arbiter. All the arbiters work in parallel, and each picks the highest-priority node that is pending, enabled and routed to that provider. The winning priority number is passed to the provider. The provider uses it directly as an index into its interrupt table, so no decoding step is needed.

The outgoing interface of each provider is a valid/ready pair carrying the priority number. The rules for back-pressure are as follows. When `irq_valid_o` is high and `irq_ready_i` is low, the node stays pending and an offer stays up. The offered number can still rise if a higher-priority node arrives in the meantime, because arbitration is re-evaluated every cycle. An offer is accepted on a rising clock edge where valid and ready are both high. At that edge the winning node's flag is cleared, and the next winner for that provider is registered at the same edge. Software writes node configuration, and sets or clears flags, through a plain register port.

Top module: `srn_arb_top`

## Requirements
- R1: A node whose priority number is 0 is never offered, even when its flag is set. Every offered priority lies in the range 1 to 255.
- R2: For each provider, the offered priority equals the highest priority among the nodes that are pending, enabled and routed to that provider.
- R3: When two or more eligible nodes share the top priority, the node with the lowest index wins.
- R4: While a node's enable bit is 0, its pending flag is kept but never offered. Setting the enable bit later makes the node eligible.
- R5: The target field (provider index 0 to NUM_PROV-1) routes a node to exactly one provider, and each provider is arbitrated independently of the others.
- R6: An offer is made only when the winning priority is strictly greater than that provider's `run_prio_i` value, sampled in the cycle before the offer.
- R7: An accepted offer (valid and ready both high at a clock edge) clears the winning node's flag at that edge. In the following cycle the next winner is offered, or valid drops if no eligible node remains.
- R8: A hardware request pulse sets the node's flag. The matching offer appears one clock edge after the request.
- R9: Software can set a node's flag (`sw_set_i`) or clear it (`sw_clr_i`), with the node chosen by `cfg_node_i`. If both are asserted in the same cycle, set wins. Configuration writes (`cfg_we_i`) affect arbitration from the second edge after the write.
- R10: A hardware request in the same cycle as a software clear, or as an acceptance of that node, leaves the flag set.
- R11: Without ready, a pending offer is held indefinitely. It is replaced only by a higher-priority arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_req_i | input | NUM_NODES | Hardware request pulses, one bit per node |
| cfg_we_i | input | 1 | Write configuration of node `cfg_node_i` |
| cfg_node_i | input | IDX_W | Node addressed by writes and software flag operations |
| cfg_prio_i | input | 8 | Priority number to write (0 = never offered) |
| cfg_en_i | input | 1 | Enable bit to write |
| cfg_tgt_i | input | 2 | Provider index to write |
| sw_set_i | input | 1 | Software set of the addressed node's flag |
| sw_clr_i | input | 1 | Software clear of the addressed node's flag |
| run_prio_i | input | NUM_PROV*8 | Running priority of each provider |
| irq_ready_i | input | NUM_PROV | Provider accepts the current offer |
| irq_valid_o | output | NUM_PROV | Offer present for the provider |
| irq_prio_o | output | NUM_PROV*8 | Offered priority number (table index) per provider |

## Verification
The assertions check on every cycle that an offered priority is never zero and always exceeds the provider's previous running priority. They also check that the offered node is actually pending, that an accepted flag is gone after the edge unless something set it again, and that a hardware request always leaves its flag set. Which node wins among several, the lowest-index tie-break, routing to separate providers, the held flag of a disabled or zero-priority node, and the back-pressure behaviour can only be seen through the bench's directed scenarios. In each of those scenarios, follow-up acknowledges or configuration writes show which flag remained.

// File: rtl/srn_pkg.sv
package srn_pkg;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned TGT_W  = 2;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic             en;
    logic [TGT_W-1:0] tgt;
    prio_t            prio;
  } node_cfg_t;
endpackage

// File: rtl/srn_node_bank.sv
module srn_node_bank
  import srn_pkg::*;
#(
  parameter int unsigned NUM_NODES = 8,
  localparam int unsigned IDX_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_NODES-1:0]        hw_req_i,
  input  logic                        cfg_we_i,
  input  logic [IDX_W-1:0]            cfg_node_i,
  input  node_cfg_t                   cfg_wdata_i,
  input  logic                        sw_set_i,
  input  logic                        sw_clr_i,
  input  logic [NUM_NODES-1:0]        ack_clr_i,
  output logic [NUM_NODES-1:0]        flag_d_o,
  output logic [NUM_NODES-1:0]        flag_q_o,
  output node_cfg_t [NUM_NODES-1:0]   cfg_q_o
);
  logic [NUM_NODES-1:0] set_vec;
  logic [NUM_NODES-1:0] clr_vec;

  for (genvar n = 0; n < NUM_NODES; n++) begin : g_node
    logic hit;
    assign hit        = (cfg_node_i == IDX_W'(n));
    assign set_vec[n] = hw_req_i[n] | (sw_set_i & hit);
    assign clr_vec[n] = ack_clr_i[n] | (sw_clr_i & hit);
    // a set always beats a clear from software or from acceptance
    assign flag_d_o[n] = set_vec[n] | (flag_q_o[n] & ~clr_vec[n]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q_o[n] <= 1'b0;
        cfg_q_o[n]  <= '0;
      end else begin
        flag_q_o[n] <= flag_d_o[n];
        if (cfg_we_i && hit) cfg_q_o[n] <= cfg_wdata_i;
      end
    end
  end

  AST_HW_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_req_i != '0) |=> ((flag_q_o & $past(hw_req_i)) == $past(hw_req_i))); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ack_clr_i & ~hw_req_i) != '0 && !sw_set_i) |=>
      ((flag_q_o & $past(ack_clr_i & ~hw_req_i)) == '0)); // R7
endmodule

// File: rtl/srn_prio_select.sv
module srn_prio_select
  import srn_pkg::*;
#(
  parameter int unsigned NUM_NODES = 8,
  parameter int unsigned PROV_ID   = 0,
  localparam int unsigned IDX_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic [NUM_NODES-1:0]      pend_i,
  input  node_cfg_t [NUM_NODES-1:0] cfg_i,
  output logic                      found_o,
  output prio_t                     best_prio_o,
  output logic [IDX_W-1:0]          best_idx_o
);
  always_comb begin
    best_prio_o = '0;
    best_idx_o  = '0;
    // strict compare keeps the lowest index on a tie; priority 0 never beats the start value
    for (int i = 0; i < NUM_NODES; i++) begin
      if (pend_i[i] && cfg_i[i].en && (cfg_i[i].tgt == TGT_W'(PROV_ID))
          && (cfg_i[i].prio > best_prio_o)) begin
        best_prio_o = cfg_i[i].prio;
        best_idx_o  = IDX_W'(i);
      end
    end
    found_o = (best_prio_o != '0);
  end
endmodule

// File: rtl/srn_arb_top.sv
module srn_arb_top
  import srn_pkg::*;
#(
  parameter int unsigned NUM_NODES = 8,
  parameter int unsigned NUM_PROV  = 3,
  localparam int unsigned IDX_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_NODES-1:0]       hw_req_i,
  input  logic                       cfg_we_i,
  input  logic [IDX_W-1:0]           cfg_node_i,
  input  logic [PRIO_W-1:0]          cfg_prio_i,
  input  logic                       cfg_en_i,
  input  logic [TGT_W-1:0]           cfg_tgt_i,
  input  logic                       sw_set_i,
  input  logic                       sw_clr_i,
  input  logic [NUM_PROV*PRIO_W-1:0] run_prio_i,
  input  logic [NUM_PROV-1:0]        irq_ready_i,
  output logic [NUM_PROV-1:0]        irq_valid_o,
  output logic [NUM_PROV*PRIO_W-1:0] irq_prio_o
);
  node_cfg_t [NUM_NODES-1:0] cfg_q;
  node_cfg_t                 cfg_wdata;
  logic [NUM_NODES-1:0]      flag_d, flag_q, ack_clr;
  logic [IDX_W-1:0]          idx_q [NUM_PROV];

  assign cfg_wdata = '{en: cfg_en_i, tgt: cfg_tgt_i, prio: cfg_prio_i};

  always_comb begin
    ack_clr = '0;
    for (int p = 0; p < NUM_PROV; p++)
      if (irq_valid_o[p] && irq_ready_i[p]) ack_clr[idx_q[p]] = 1'b1;
  end

  srn_node_bank #(.NUM_NODES(NUM_NODES)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_req_i   (hw_req_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_node_i (cfg_node_i),
    .cfg_wdata_i(cfg_wdata),
    .sw_set_i   (sw_set_i),
    .sw_clr_i   (sw_clr_i),
    .ack_clr_i  (ack_clr),
    .flag_d_o   (flag_d),
    .flag_q_o   (flag_q),
    .cfg_q_o    (cfg_q)
  );

  for (genvar p = 0; p < NUM_PROV; p++) begin : g_prov
    logic             found;
    prio_t            best_prio;
    logic [IDX_W-1:0] best_idx;
    prio_t            run_prio;
    prio_t            prio_q;

    assign run_prio = run_prio_i[p*PRIO_W +: PRIO_W];

    srn_prio_select #(.NUM_NODES(NUM_NODES), .PROV_ID(p)) u_sel (
      .pend_i     (flag_d),
      .cfg_i      (cfg_q),
      .found_o    (found),
      .best_prio_o(best_prio),
      .best_idx_o (best_idx)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_valid_o[p] <= 1'b0;
        prio_q         <= '0;
        idx_q[p]       <= '0;
      end else begin
        irq_valid_o[p] <= found && (best_prio > run_prio);
        prio_q         <= best_prio;
        idx_q[p]       <= best_idx;
      end
    end

    assign irq_prio_o[p*PRIO_W +: PRIO_W] = irq_valid_o[p] ? prio_q : '0;

    AST_PRIO_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_valid_o[p] |-> (prio_q != '0)); // R1

    AST_ABOVE_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_valid_o[p] |-> (prio_q > $past(run_prio))); // R6

    AST_WINNER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_valid_o[p] |-> flag_q[idx_q[p]]); // R2
  end
endmodule

// File: tb/tb_srn_arb_top.sv
module tb_srn_arb_top;
  localparam int N = 8;
  localparam int P = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   hw_req = '0;
  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_node = '0;
  logic [7:0]     cfg_prio = '0;
  logic           cfg_en = 1'b0;
  logic [1:0]     cfg_tgt = '0;
  logic           sw_set = 1'b0, sw_clr = 1'b0;
  logic [P*8-1:0] run_prio = '0;
  logic [P-1:0]   ready = '0;
  logic [P-1:0]   valid;
  logic [P*8-1:0] prio;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  srn_arb_top #(.NUM_NODES(N), .NUM_PROV(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .cfg_we_i(cfg_we),
    .cfg_node_i(cfg_node), .cfg_prio_i(cfg_prio), .cfg_en_i(cfg_en),
    .cfg_tgt_i(cfg_tgt), .sw_set_i(sw_set), .sw_clr_i(sw_clr),
    .run_prio_i(run_prio), .irq_ready_i(ready), .irq_valid_o(valid),
    .irq_prio_o(prio)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic offer(input string req, input int p, input bit v, input int pr);
    check({req, " valid"}, int'(valid[p]), int'(v));
    check({req, " prio"}, int'(prio[p*8 +: 8]), v ? pr : 0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hw_req = '0; cfg_we = 0; sw_set = 0; sw_clr = 0;
    run_prio = '0; ready = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr(input int node, input int pr, input bit en, input int tgt);
    cfg_we = 1'b1; cfg_node = 3'(node); cfg_prio = 8'(pr); cfg_en = en; cfg_tgt = 2'(tgt);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input logic [N-1:0] hw, input int node, input bit s, input bit c,
                     input logic [P-1:0] rdy);
    hw_req = hw; cfg_node = 3'(node); sw_set = s; sw_clr = c; ready = rdy;
    step();
    hw_req = '0; sw_set = 0; sw_clr = 0; ready = '0;
  endtask

  task automatic t_reset();
    do_reset();
    for (int p = 0; p < P; p++) offer("R1 reset", p, 0, 0);
  endtask

  task automatic t_basic();
    do_reset();
    wr(2, 10, 1, 0); wr(5, 40, 1, 0); step();
    cyc(8'b0010_0100, 0, 0, 0, '0);
    offer("R8 R2 highest wins", 0, 1, 40);
    cyc('0, 0, 0, 0, 3'b001);
    offer("R7 next winner", 0, 1, 10);
    cyc('0, 0, 0, 0, 3'b001);
    offer("R7 drained", 0, 0, 0);
  endtask

  task automatic t_tie();
    do_reset();
    wr(1, 20, 1, 0); wr(6, 20, 1, 0); step();
    cyc(8'b0100_0010, 0, 0, 0, '0);
    offer("R3 tie", 0, 1, 20);
    cyc('0, 0, 0, 0, 3'b001);
    wr(6, 5, 1, 0); step();
    offer("R3 lowest index taken first", 0, 1, 5);
  endtask

  task automatic t_zero_disable();
    do_reset();
    wr(3, 0, 1, 0); wr(4, 50, 0, 0); step();
    cyc(8'b0001_1000, 0, 0, 0, '0);
    offer("R1 R4 zero and disabled", 0, 0, 0);
    repeat (3) step();
    offer("R4 still silent", 0, 0, 0);
    wr(3, 7, 1, 0); step();
    offer("R1 flag kept under zero", 0, 1, 7);
    wr(4, 50, 1, 0); step();
    offer("R4 enabled later", 0, 1, 50);
  endtask

  task automatic t_route();
    do_reset();
    wr(0, 30, 1, 0); wr(1, 60, 1, 1); wr(2, 90, 1, 2); step();
    cyc(8'b0000_0111, 0, 0, 0, '0);
    offer("R5 prov0", 0, 1, 30);
    offer("R5 prov1", 1, 1, 60);
    offer("R5 prov2", 2, 1, 90);
    cyc('0, 0, 0, 0, 3'b010);
    offer("R5 prov1 acked", 1, 0, 0);
    offer("R5 prov0 untouched", 0, 1, 30);
    offer("R5 prov2 untouched", 2, 1, 90);
  endtask

  task automatic t_running();
    do_reset();
    wr(0, 30, 1, 0); step();
    run_prio[7:0] = 8'd30;
    cyc(8'b0000_0001, 0, 0, 0, '0);
    offer("R6 equal blocks", 0, 0, 0);
    run_prio[7:0] = 8'd29;
    step();
    offer("R6 lower passes", 0, 1, 30);
    run_prio[7:0] = 8'd0;
  endtask

  task automatic t_software();
    do_reset();
    wr(7, 12, 1, 0); step();
    cyc('0, 7, 1, 0, '0);
    offer("R9 sw set", 0, 1, 12);
    cyc('0, 7, 0, 1, '0);
    offer("R9 sw clear", 0, 0, 0);
    cyc('0, 7, 1, 1, '0);
    offer("R9 set beats clear", 0, 1, 12);
    cyc(8'b1000_0000, 7, 0, 1, '0);
    offer("R10 hw beats sw clear", 0, 1, 12);
    cyc(8'b1000_0000, 7, 0, 0, 3'b001);
    offer("R10 hw beats accept", 0, 1, 12);
    cyc('0, 0, 0, 0, 3'b001);
    offer("R7 accept clears", 0, 0, 0);
  endtask

  task automatic t_backpressure();
    do_reset();
    wr(2, 10, 1, 0); wr(5, 40, 1, 0); step();
    cyc(8'b0000_0100, 0, 0, 0, '0);
    repeat (5) step();
    offer("R11 held without ready", 0, 1, 10);
    cyc(8'b0010_0000, 0, 0, 0, '0);
    offer("R11 replaced by higher", 0, 1, 40);
    cyc('0, 0, 0, 0, 3'b001);
    offer("R11 lower still pending", 0, 1, 10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_tie();
    t_zero_disable();
    t_route();
    t_running();
    t_software();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule